// File: doc/BRIEF.md
# Character Grid Address and Cursor Generator

This block turns the raster position of a text overlay into the read address of the display character memory. The raster position comes in as three counters: a character column, a physical line slot and a dot row inside the cell. Two grid layouts are supported. The wide layout has 24 columns on each of 10 text lines. The narrow layout has 32 columns on each of 7 text lines. In both layouts the cells are numbered line by line, so the address of a cell is its zero-based text line times the column count, plus its column.

When spacing is enabled, blank slots are inserted into the stack of physical line slots. In the wide layout there are two: one after text line 2 and one after text line 8. The narrow layout keeps only the blank after text line 2. Each slot is classified into one of three kinds. A TEXT slot carries a text line. A SPACER slot is an inserted blank. An OUTSIDE slot lies below the last text line. The address output and the valid flag depend on that kind.

A cursor is marked by comparing the cell address with an 8-bit cursor code. The cursor appears only on one dot row of the cell, and a select input chooses between two adjacent rows. The code 0xFF switches the cursor off. Any code beyond the last cell of the current layout is also treated as off. All outputs are registered, one character clock ahead of the pixel path, so that the memory read latency is covered.

Top module: `grid_addr_cursor`

## Requirements
- R1: While rst_n is low, ram_addr, cell_valid and cursor_on are all 0.
- R2: With mode32=0 and spacer_en=0, a slot s from 0 to 9 and a column c from 0 to 23 give cell_valid=1 and ram_addr=s*24+c, which spans 0x00 to 0xEF.
- R3: With mode32=1 and spacer_en=0, a slot s from 0 to 6 and a column c from 0 to 31 give cell_valid=1 and ram_addr=s*32+c, which spans 0x00 to 0xDF.
- R4: A column at or beyond the column count of the layout gives cell_valid=0 and ram_addr=0. So does a slot at or beyond the last slot of the layout.
- R5: With mode32=0 and spacer_en=1, slots 2 and 9 are blank (cell_valid=0, ram_addr=0). Slots 0-1 carry text lines 0-1, slots 3-8 carry lines 2-7, slots 10-11 carry lines 8-9, and slots 12 and above are outside the grid.
- R6: With mode32=1 and spacer_en=1, only slot 2 is blank. Slots 0-1 carry text lines 0-1, slots 3-7 carry lines 2-6, and slots 8 and above are outside the grid.
- R7: cursor_on is 1 only when all of these hold: the cell is valid, ram_addr equals cursor_addr, and dot_row equals 16 (with cursor_row_sel=0) or 17 (with cursor_row_sel=1). Dot rows are counted from 0.
- R8: A cursor_addr of 0xFF never produces cursor_on.
- R9: A cursor_addr at or above the cell count of the layout never produces cursor_on. The cell count is 240 for the wide layout and 224 for the narrow one, so 0xF0 is off in the wide layout and 0xE0 is off in the narrow one.
- R10: Each output reflects the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_i | input | 5 | Character column counter |
| slot_i | input | 4 | Physical line slot counter |
| dot_row_i | input | 5 | Dot row within the cell |
| mode32_i | input | 1 | 0 selects 24x10, 1 selects 32x7 |
| spacer_en_i | input | 1 | Enables the inserted blank slots |
| cursor_addr_i | input | 8 | Cursor cell code, 0xFF means off |
| cursor_row_sel_i | input | 1 | 0 selects dot row 16, 1 selects dot row 17 |
| ram_addr_o | output | 8 | Registered display memory read address |
| cell_valid_o | output | 1 | Registered flag for a cell inside the grid |
| cursor_on_o | output | 1 | Registered cursor mark |

## Verification
Full sweeps of every slot and column are run in all four combinations of layout and spacing. These sweeps separate the two column multipliers from each other, and separate the placement of the spacer slots from the plain slot-to-line mapping. Cursor sweeps at dot rows 15, 16 and 17 under both row selects tell apart the address match from the dot-row gate. Cursor codes at the first cell, the last cell, 0xE0, 0xF0 and 0xFF show the boundary between legal and off codes in each layout. A final random phase changes every input on every clock, so that any extra or missing pipeline stage shows up.

// File: rtl/grid_pkg.sv
package grid_pkg;
    typedef enum logic [1:0] {
        SLOT_TEXT    = 2'd0,
        SLOT_SPACER  = 2'd1,
        SLOT_OUTSIDE = 2'd2
    } slot_kind_t;
endpackage

// File: rtl/grid_line_map.sv
module grid_line_map
    import grid_pkg::*;
#(
    parameter int LINE_W       = 4,
    parameter int LINES_WIDE   = 10,
    parameter int LINES_NARROW = 7,
    parameter int GAP_LO       = 2,
    parameter int GAP_HI       = 8
) (
    input  logic [LINE_W-1:0] slot_i,
    input  logic              mode32_i,
    input  logic              spacer_en_i,
    output slot_kind_t        kind_o,
    output logic [LINE_W-1:0] line_o
);
    localparam logic [LINE_W-1:0] LO_SLOT      = LINE_W'(GAP_LO);
    localparam logic [LINE_W-1:0] HI_SLOT      = LINE_W'(GAP_HI + 1);
    localparam logic [LINE_W-1:0] END_NARROW   = LINE_W'(LINES_NARROW + 1);
    localparam logic [LINE_W-1:0] END_WIDE     = LINE_W'(LINES_WIDE + 2);
    localparam logic [LINE_W-1:0] PLAIN_NARROW = LINE_W'(LINES_NARROW);
    localparam logic [LINE_W-1:0] PLAIN_WIDE   = LINE_W'(LINES_WIDE);

    logic [LINE_W-1:0] plain_end;
    assign plain_end = mode32_i ? PLAIN_NARROW : PLAIN_WIDE;

    always_comb begin
        kind_o = SLOT_OUTSIDE;
        line_o = '0;
        if (!spacer_en_i) begin
            if (slot_i < plain_end) begin
                kind_o = SLOT_TEXT;
                line_o = slot_i;
            end
        end else if (slot_i < LO_SLOT) begin
            kind_o = SLOT_TEXT;
            line_o = slot_i;
        end else if (slot_i == LO_SLOT) begin
            kind_o = SLOT_SPACER;
        end else if (mode32_i) begin
            if (slot_i < END_NARROW) begin
                kind_o = SLOT_TEXT;
                line_o = slot_i - LINE_W'(1);
            end
        end else if (slot_i < HI_SLOT) begin
            kind_o = SLOT_TEXT;
            line_o = slot_i - LINE_W'(1);
        end else if (slot_i == HI_SLOT) begin
            kind_o = SLOT_SPACER;
        end else if (slot_i < END_WIDE) begin
            kind_o = SLOT_TEXT;
            line_o = slot_i - LINE_W'(2);
        end
    end
endmodule

// File: rtl/grid_cell_addr.sv
module grid_cell_addr
    import grid_pkg::*;
#(
    parameter int COL_W      = 5,
    parameter int LINE_W     = 4,
    parameter int ADDR_W     = 8,
    parameter int COLS_WIDE  = 24,
    parameter int COLS_NARROW = 32
) (
    input  slot_kind_t        kind_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              mode32_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o
);
    localparam logic [COL_W:0] NCOL_W = (COL_W+1)'(COLS_WIDE);
    localparam logic [COL_W:0] NCOL_N = (COL_W+1)'(COLS_NARROW);

    logic [COL_W:0]  ncols;
    logic            col_ok;
    logic [ADDR_W-1:0] lin_addr;

    assign ncols    = mode32_i ? NCOL_N : NCOL_W;
    assign col_ok   = {1'b0, col_i} < ncols;
    assign lin_addr = ADDR_W'(line_i) * ADDR_W'(ncols) + ADDR_W'(col_i);

    always_comb begin
        valid_o = 1'b0;
        addr_o  = '0;
        unique case (kind_i)
            SLOT_TEXT: begin
                valid_o = col_ok;
                addr_o  = col_ok ? lin_addr : '0;
            end
            SLOT_SPACER:  valid_o = 1'b0;
            SLOT_OUTSIDE: valid_o = 1'b0;
            default:      valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/grid_cursor_cmp.sv
module grid_cursor_cmp #(
    parameter int ADDR_W      = 8,
    parameter int DOT_W       = 5,
    parameter int CELLS_WIDE  = 240,
    parameter int CELLS_NARROW = 224,
    parameter int ROW_LO      = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] cursor_i,
    input  logic              mode32_i,
    input  logic [DOT_W-1:0]  dot_row_i,
    input  logic              row_sel_i,
    output logic              hit_o
);
    localparam logic [ADDR_W:0] LIM_W = (ADDR_W+1)'(CELLS_WIDE);
    localparam logic [ADDR_W:0] LIM_N = (ADDR_W+1)'(CELLS_NARROW);
    localparam logic [DOT_W-1:0] R_LO = DOT_W'(ROW_LO);
    localparam logic [DOT_W-1:0] R_HI = DOT_W'(ROW_LO + 1);

    logic legal, row_ok;
    assign legal  = {1'b0, cursor_i} < (mode32_i ? LIM_N : LIM_W);
    assign row_ok = dot_row_i == (row_sel_i ? R_HI : R_LO);
    assign hit_o  = valid_i && legal && row_ok && (addr_i == cursor_i);
endmodule

// File: rtl/grid_addr_cursor.sv
module grid_addr_cursor
    import grid_pkg::*;
#(
    parameter int COL_W        = 5,
    parameter int LINE_W       = 4,
    parameter int DOT_W        = 5,
    parameter int ADDR_W       = 8,
    parameter int COLS_WIDE    = 24,
    parameter int LINES_WIDE   = 10,
    parameter int COLS_NARROW  = 32,
    parameter int LINES_NARROW = 7,
    parameter int GAP_LO       = 2,
    parameter int GAP_HI       = 8,
    parameter int CURSOR_ROW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  col_i,
    input  logic [LINE_W-1:0] slot_i,
    input  logic [DOT_W-1:0]  dot_row_i,
    input  logic              mode32_i,
    input  logic              spacer_en_i,
    input  logic [ADDR_W-1:0] cursor_addr_i,
    input  logic              cursor_row_sel_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic              cell_valid_o,
    output logic              cursor_on_o
);
    localparam int CELLS_WIDE   = COLS_WIDE * LINES_WIDE;
    localparam int CELLS_NARROW = COLS_NARROW * LINES_NARROW;
    localparam logic [ADDR_W-1:0] TOP_NARROW = ADDR_W'(CELLS_NARROW - 1);
    localparam logic [ADDR_W-1:0] OFF_CODE   = '1;

    slot_kind_t        kind;
    logic [LINE_W-1:0] text_line;
    logic [ADDR_W-1:0] addr_d;
    logic              valid_d, hit_d;

    grid_line_map #(
        .LINE_W(LINE_W), .LINES_WIDE(LINES_WIDE), .LINES_NARROW(LINES_NARROW),
        .GAP_LO(GAP_LO), .GAP_HI(GAP_HI)
    ) u_map (
        .slot_i(slot_i), .mode32_i(mode32_i), .spacer_en_i(spacer_en_i),
        .kind_o(kind), .line_o(text_line)
    );

    grid_cell_addr #(
        .COL_W(COL_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W),
        .COLS_WIDE(COLS_WIDE), .COLS_NARROW(COLS_NARROW)
    ) u_addr (
        .kind_i(kind), .line_i(text_line), .col_i(col_i), .mode32_i(mode32_i),
        .addr_o(addr_d), .valid_o(valid_d)
    );

    grid_cursor_cmp #(
        .ADDR_W(ADDR_W), .DOT_W(DOT_W), .CELLS_WIDE(CELLS_WIDE),
        .CELLS_NARROW(CELLS_NARROW), .ROW_LO(CURSOR_ROW)
    ) u_cur (
        .addr_i(addr_d), .valid_i(valid_d), .cursor_i(cursor_addr_i),
        .mode32_i(mode32_i), .dot_row_i(dot_row_i), .row_sel_i(cursor_row_sel_i),
        .hit_o(hit_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_addr_o   <= '0;
            cell_valid_o <= 1'b0;
            cursor_on_o  <= 1'b0;
        end else begin
            ram_addr_o   <= addr_d;
            cell_valid_o <= valid_d;
            cursor_on_o  <= hit_d;
        end
    end

    // R3: narrow layout never addresses beyond its last cell
    p_narrow_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode32_i |=> (!cell_valid_o || ram_addr_o <= TOP_NARROW));

    // R5: the first inserted slot is always blank
    p_spacer_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spacer_en_i && slot_i == LINE_W'(GAP_LO)) |=> !cell_valid_o);

    // R7: cursor only marks a valid cell
    p_cursor_in_cell_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_on_o |-> cell_valid_o);

    // R7: cursor only on the two selectable dot rows
    p_cursor_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_row_i != DOT_W'(CURSOR_ROW) && dot_row_i != DOT_W'(CURSOR_ROW + 1))
        |=> !cursor_on_o);

    // R8: off code suppresses the cursor
    p_off_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cursor_addr_i == OFF_CODE) |=> !cursor_on_o);

    // R4: invalid cell reads address zero
    p_idle_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_valid_o |-> (ram_addr_o == '0));
endmodule

// File: tb/tb_grid_addr_cursor.sv
module tb_grid_addr_cursor;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] col = '0;
    logic [3:0] slot = '0;
    logic [4:0] dot = '0;
    logic       m32 = 1'b0;
    logic       sp = 1'b0;
    logic [7:0] cur = 8'hFF;
    logic       rsel = 1'b0;
    logic [7:0] ram_addr;
    logic       cell_valid, cursor_on;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int    addr;
        bit    v;
        bit    c;
        string tag;
    } exp_t;
    exp_t pend[$];

    grid_addr_cursor dut (
        .clk(clk), .rst_n(rst_n), .col_i(col), .slot_i(slot), .dot_row_i(dot),
        .mode32_i(m32), .spacer_en_i(sp), .cursor_addr_i(cur),
        .cursor_row_sel_i(rsel), .ram_addr_o(ram_addr),
        .cell_valid_o(cell_valid), .cursor_on_o(cursor_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic exp_t model(int s, int c, int d, bit w32, bit spc,
                                   bit sel, int cu, string tag);
        exp_t e;
        int cols  = w32 ? 32 : 24;
        int lines = w32 ? 7 : 10;
        int ln = -1;
        for (int k = 0; k < lines; k++) begin
            int phys = k;
            if (spc && k >= 2) phys++;
            if (spc && !w32 && k >= 8) phys++;
            if (phys == s) ln = k;
        end
        e.v    = (ln >= 0) && (c < cols);
        e.addr = e.v ? ln * cols + c : 0;
        e.c    = e.v && (cu < lines * cols) && (e.addr == cu) &&
                 (d == (sel ? 17 : 16));
        e.tag  = tag;
        return e;
    endfunction

    task automatic check_pending();
        exp_t e;
        bit bad;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        n_cmp++;
        bad = 0;
        if (int'(ram_addr) != e.addr) begin
            $display("FAIL %s ram_addr act=%0h exp=%0h", e.tag, ram_addr, e.addr);
            bad = 1;
        end
        if (cell_valid != e.v) begin
            $display("FAIL %s cell_valid act=%0b exp=%0b", e.tag, cell_valid, e.v);
            bad = 1;
        end
        if (cursor_on != e.c) begin
            $display("FAIL %s cursor_on act=%0b exp=%0b", e.tag, cursor_on, e.c);
            bad = 1;
        end
        if (bad) n_bad++;
    endtask

    task automatic step(int s, int c, int d, bit w32, bit spc, bit sel,
                        int cu, string tag);
        @(negedge clk);
        check_pending();
        slot = 4'(s); col = 5'(c); dot = 5'(d);
        m32 = w32; sp = spc; rsel = sel; cur = 8'(cu);
        pend.push_back(model(s, c, d, w32, spc, sel, cu, tag));
    endtask

    task automatic sweep(bit w32, bit spc, int d, bit sel, int cu, string tag);
        for (int s = 0; s < 16; s++)
            for (int c = 0; c < 32; c++)
                step(s, c, d, w32, spc, sel, cu, tag);
    endtask

    task automatic reset_check(string tag);
        n_cmp++;
        if (ram_addr != 8'h00 || cell_valid || cursor_on) begin
            $display("FAIL %s reset act=%0h/%0b/%0b exp=0/0/0",
                     tag, ram_addr, cell_valid, cursor_on);
            n_bad++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero in reset while inputs point at a cursor cell
        slot = 4'd0; col = 5'd0; dot = 5'd16; cur = 8'h00;
        repeat (3) @(negedge clk);
        reset_check("R1");
        @(negedge clk);
        reset_check("R1");
        rst_n = 1'b1;

        sweep(1'b0, 1'b0, 0, 1'b0, 255, "R2");   // also R4 beyond grid
        sweep(1'b1, 1'b0, 0, 1'b0, 255, "R3");
        sweep(1'b0, 1'b0, 3, 1'b0, 255, "R4");
        sweep(1'b0, 1'b1, 0, 1'b0, 255, "R5");
        sweep(1'b1, 1'b1, 0, 1'b0, 255, "R6");

        // R7: cursor match and dot-row gate, both row selects
        for (int d = 15; d <= 17; d++) begin
            sweep(1'b0, 1'b0, d, 1'b0, 37, "R7");
            sweep(1'b0, 1'b1, d, 1'b1, 239, "R7");
            sweep(1'b1, 1'b1, d, 1'b0, 223, "R7");
            sweep(1'b1, 1'b0, d, 1'b1, 0, "R7");
        end

        // R8: off code
        sweep(1'b0, 1'b0, 16, 1'b0, 255, "R8");
        sweep(1'b1, 1'b0, 17, 1'b1, 255, "R8");

        // R9: codes beyond the last cell of each layout
        sweep(1'b0, 1'b0, 16, 1'b0, 240, "R9");
        sweep(1'b1, 1'b0, 16, 1'b0, 224, "R9");
        sweep(1'b1, 1'b1, 17, 1'b1, 230, "R9");

        // R10: every input changes on every clock
        for (int i = 0; i < 4000; i++)
            step($urandom_range(15), $urandom_range(31), $urandom_range(15, 18),
                 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom_range(3) == 0) ? 255 : $urandom_range(239), "R10");

        @(negedge clk);
        check_pending();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule